// File: doc/BRIEF.md
# Loopback Upset Monitor

The block sends a four-lane test pattern out to an external line driver and receiver chain, takes the four lanes that come back, and compares them with what it sent. Each lane that returns a wrong value starts an upset event. A run of consecutive wrong samples on one lane counts as a single event. Each event is binned by how many sample edges it lasted and by the direction of the bit flip, and all counts are kept separately for each lane.

The pattern alternates between a checkerboard word and its inverse, and each value is held for two system-clock cycles. The returned lanes pass through a two-stage synchroniser. The transmitted pattern is delayed by a programmable extra latency so that it lines up with the returned data. Comparison starts only after the loop has had time to fill. Software reads the counters through a small address/data read port and zeroes them with a one-cycle clear strobe.

Each lane has its own tracker state machine with four states. `TRK_IDLE` means no event is open. `TRK_ONE` means one mismatching edge has been seen. `TRK_TWO` means two consecutive mismatching edges have been seen. `TRK_MANY` means three or more have been seen. The transitions are:

- start: `TRK_IDLE` to `TRK_ONE` on a compared mismatch.
- extend: `TRK_ONE` to `TRK_TWO`, and `TRK_TWO` to `TRK_MANY`, on a further mismatch.
- overrun: `TRK_MANY` stays in `TRK_MANY` on a further mismatch and raises the long-error flag.
- close: any of `TRK_ONE`, `TRK_TWO` or `TRK_MANY` goes back to `TRK_IDLE` when the sample matches or when comparison is disabled. The close emits one event carrying its length bin.

Top module: `lum_monitor`

## Requirements
- R1: After reset, `pat_o` is 4'b0101 (lanes 0 and 2 high), every counter reads 0, and `long_flag_o` is 0.
- R2: While `run_en` is low, `pat_o` is 4'b0101. While it is high, `pat_o` alternates between 4'b0101 and 4'b1010, and each value is held for exactly two cycles. The first inverted word appears after the second rising edge with `run_en` high.
- R3: On the edge that samples a returned lane, the value taken through the two-stage synchroniser is compared with `pat_o` as it was `lat_sel` (0 to 7) cycles earlier than the value that was sampled into the synchroniser at the same time. A loop whose own delay is `lat_sel` cycles therefore produces no events.
- R4: The first 8 rising edges with `run_en` high after it rises are not compared. Mismatches on those edges create no events.
- R5: Consecutive compared mismatching edges on one lane form one event. The event closes on the first matching edge or on the first edge where comparison is disabled. When it closes, the lane's total counter (kind 0) increments once.
- R6: A closing event increments exactly one length bin: kind 1 for one edge, kind 2 for two edges, kind 3 for three or more edges.
- R7: A closing event increments kind 4 when its first mismatching sample expected 1 and read 0. It increments kind 5 when that sample expected 0 and read 1.
- R8: `long_flag_o[lane]` sets on the fourth consecutive mismatching edge of an event. It stays set until `clr_cnt`.
- R9: Every counter is 16 bits wide and stops at 65535 instead of wrapping.
- R10: A cycle with `clr_cnt` high zeroes every counter and every long flag. This takes priority over any increment or flag set on that edge.
- R11: `rd_addr` = lane*8 + kind. `rd_data` shows that counter on the same cycle. Kinds 6 and 7 read 0.
- R12: Mismatches on one lane never change the counters or the flag of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | High to transmit and compare, low to stop |
| lat_sel | input | 3 | Extra loop latency in cycles, 0 to 7 |
| clr_cnt | input | 1 | One-cycle strobe that zeroes all counters and flags |
| ret_i | input | 4 | Lanes returned from the external chain |
| rd_addr | input | 5 | Counter select, lane*8 + kind |
| pat_o | output | 4 | Transmitted test pattern |
| rd_data | output | 16 | Value of the selected counter |
| long_flag_o | output | 4 | Sticky per-lane flag for events longer than three edges |

## Verification
The pattern is tried first with a clean loop at zero and at five cycles of latency. This separates a correct alignment of the expected and returned data from an off-by-one in the delay tap. Single-edge, two-edge, three-edge and five-edge error bursts are injected on chosen lanes at known pattern phases. These separate the length bins, the 1-to-0 and 0-to-1 direction bins, the long flag and lane isolation. Bursts placed inside the start-up mask and across a stop show the masking and forced-close behaviour. A long train of alternating single-edge errors drives a counter into saturation.

// File: rtl/lum_pkg.sv
package lum_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_ONE  = 2'd1,
        TRK_TWO  = 2'd2,
        TRK_MANY = 2'd3
    } trk_state_t;

    localparam int NUM_KINDS  = 6;
    localparam int KIND_TOTAL = 0;
    localparam int KIND_LEN1  = 1;
    localparam int KIND_FALL  = 4;
    localparam int KIND_RISE  = 5;
    localparam int KIND_BITS  = 3;

endpackage

// File: rtl/lum_patgen.sv
module lum_patgen #(
    parameter int LANES    = 4,
    parameter int MAX_LAT  = 7,
    parameter int MASK_CYC = 8,
    parameter int LAT_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [LAT_W-1:0] lat_sel,
    input  logic [LANES-1:0] ret_i,
    output logic [LANES-1:0] pat_o,
    output logic [LANES-1:0] exp_o,
    output logic [LANES-1:0] smp_o,
    output logic             cmp_en_o
);
    localparam int DEPTH = MAX_LAT + 2;
    localparam int MW    = $clog2(MASK_CYC + 1);
    localparam logic [MW-1:0] MASK_LIM = MW'(MASK_CYC);

    function automatic logic [LANES-1:0] mk_board();
        logic [LANES-1:0] w;
        for (int i = 0; i < LANES; i++) begin
            w[i] = ((i % 2) == 0);
        end
        return w;
    endfunction

    localparam logic [LANES-1:0] BOARD = mk_board();

    logic [LANES-1:0] pat_q;
    logic             half_q;
    logic [LANES-1:0] sync1_q, sync2_q;
    logic [LANES-1:0] dly_q [DEPTH];
    logic [MW-1:0]    fill_q;

    // pattern source: holds each word two cycles while running
    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            pat_q  <= BOARD;
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
            if (half_q) begin
                pat_q <= ~pat_q;
            end
        end
    end

    // two-stage synchroniser on the returned lanes
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= BOARD;
            sync2_q <= BOARD;
        end else begin
            sync1_q <= ret_i;
            sync2_q <= sync1_q;
        end
    end

    // expected-data delay line
    generate
        for (genvar d = 0; d < DEPTH; d++) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    dly_q[d] <= BOARD;
                end else if (d == 0) begin
                    dly_q[d] <= pat_q;
                end else begin
                    dly_q[d] <= dly_q[(d == 0) ? 0 : d - 1];
                end
            end
        end
    endgenerate

    // start-up mask
    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            fill_q <= '0;
        end else if (fill_q != MASK_LIM) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign pat_o    = pat_q;
    assign exp_o    = dly_q[int'(lat_sel) + 1];
    assign smp_o    = sync2_q;
    assign cmp_en_o = run_en && (fill_q == MASK_LIM);

endmodule

// File: rtl/lum_lane_trk.sv
module lum_lane_trk (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_en,
    input  logic       exp_bit,
    input  logic       smp_bit,
    output logic       ev_o,
    output logic [1:0] ev_bin_o,
    output logic       ev_fall_o,
    output logic       long_set_o
);
    import lum_pkg::*;

    trk_state_t state_q, state_d;
    logic       fall_q;
    logic       miss;

    assign miss = cmp_en && (exp_bit != smp_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_IDLE;
            fall_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == TRK_IDLE && miss) begin
                fall_q <= exp_bit;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        ev_o       = 1'b0;
        ev_bin_o   = 2'd0;
        long_set_o = 1'b0;
        unique case (state_q)
            TRK_IDLE: begin
                if (miss) state_d = TRK_ONE;
            end
            TRK_ONE: begin
                if (miss) begin
                    state_d = TRK_TWO;
                end else begin
                    state_d = TRK_IDLE;
                    ev_o    = 1'b1;
                end
            end
            TRK_TWO: begin
                if (miss) begin
                    state_d = TRK_MANY;
                end else begin
                    state_d  = TRK_IDLE;
                    ev_o     = 1'b1;
                    ev_bin_o = 2'd1;
                end
            end
            TRK_MANY: begin
                if (miss) begin
                    long_set_o = 1'b1;
                end else begin
                    state_d  = TRK_IDLE;
                    ev_o     = 1'b1;
                    ev_bin_o = 2'd2;
                end
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    assign ev_fall_o = fall_q;

endmodule

// File: rtl/lum_cnt_bank.sv
module lum_cnt_bank #(
    parameter int LANES  = 4,
    parameter int CNT_W  = 16,
    parameter int LANE_W = 2,
    parameter int ADDR_W = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic [LANES-1:0]       ev,
    input  logic [LANES-1:0][1:0]  bin,
    input  logic [LANES-1:0]       fall,
    input  logic [LANES-1:0]       long_set,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [CNT_W-1:0]       rd_data,
    output logic [LANES-1:0]       long_flag
);
    import lum_pkg::*;

    logic [CNT_W-1:0] cnt_q [LANES][NUM_KINDS];
    logic [LANE_W-1:0]    lane_sel;
    logic [KIND_BITS-1:0] kind_sel;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
                logic hit;
                if (k == KIND_TOTAL) begin : g_tot
                    assign hit = ev[l];
                end else if (k == KIND_FALL) begin : g_fall
                    assign hit = ev[l] && fall[l];
                end else if (k == KIND_RISE) begin : g_rise
                    assign hit = ev[l] && !fall[l];
                end else begin : g_len
                    assign hit = ev[l] && (bin[l] == 2'(k - KIND_LEN1));
                end
                always_ff @(posedge clk) begin
                    if (rst || clr) begin
                        cnt_q[l][k] <= '0;
                    end else if (hit && (cnt_q[l][k] != '1)) begin
                        cnt_q[l][k] <= cnt_q[l][k] + 1'b1;
                    end
                end
            end
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    long_flag[l] <= 1'b0;
                end else if (long_set[l]) begin
                    long_flag[l] <= 1'b1;
                end
            end
        end
    endgenerate

    assign lane_sel = rd_addr[ADDR_W-1:KIND_BITS];
    assign kind_sel = rd_addr[KIND_BITS-1:0];

    always_comb begin
        rd_data = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int k = 0; k < NUM_KINDS; k++) begin
                if (lane_sel == LANE_W'(l) && kind_sel == KIND_BITS'(k)) begin
                    rd_data = cnt_q[l][k];
                end
            end
        end
    end

endmodule

// File: rtl/lum_monitor.sv
module lum_monitor #(
    parameter int LANES    = 4,
    parameter int CNT_W    = 16,
    parameter int MAX_LAT  = 7,
    parameter int MASK_CYC = 8,
    parameter int LAT_W    = $clog2(MAX_LAT + 1),
    parameter int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
    parameter int ADDR_W   = LANE_W + lum_pkg::KIND_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [LAT_W-1:0]  lat_sel,
    input  logic              clr_cnt,
    input  logic [LANES-1:0]  ret_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANES-1:0]  pat_o,
    output logic [CNT_W-1:0]  rd_data,
    output logic [LANES-1:0]  long_flag_o
);
    logic [LANES-1:0]      exp_w, smp_w;
    logic                  cmp_en_w;
    logic [LANES-1:0]      ev_w, fall_w, long_w;
    logic [LANES-1:0][1:0] bin_w;

    lum_patgen #(
        .LANES(LANES), .MAX_LAT(MAX_LAT), .MASK_CYC(MASK_CYC), .LAT_W(LAT_W)
    ) patgen_i (
        .clk(clk), .rst(rst), .run_en(run_en), .lat_sel(lat_sel),
        .ret_i(ret_i), .pat_o(pat_o), .exp_o(exp_w), .smp_o(smp_w),
        .cmp_en_o(cmp_en_w)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_trk
            lum_lane_trk trk_i (
                .clk(clk), .rst(rst), .cmp_en(cmp_en_w),
                .exp_bit(exp_w[l]), .smp_bit(smp_w[l]),
                .ev_o(ev_w[l]), .ev_bin_o(bin_w[l]),
                .ev_fall_o(fall_w[l]), .long_set_o(long_w[l])
            );
        end
    endgenerate

    lum_cnt_bank #(
        .LANES(LANES), .CNT_W(CNT_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)
    ) bank_i (
        .clk(clk), .rst(rst), .clr(clr_cnt), .ev(ev_w), .bin(bin_w),
        .fall(fall_w), .long_set(long_w), .rd_addr(rd_addr),
        .rd_data(rd_data), .long_flag(long_flag_o)
    );

endmodule

// File: rtl/lum_monitor_chk.sv
module lum_monitor_chk #(
    parameter int LANES  = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic              clr_cnt,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [LANES-1:0]  pat_o,
    input logic [CNT_W-1:0]  rd_data,
    input logic [LANES-1:0]  long_flag_o
);
    function automatic logic [LANES-1:0] mk_board();
        logic [LANES-1:0] w;
        for (int i = 0; i < LANES; i++) begin
            w[i] = ((i % 2) == 0);
        end
        return w;
    endfunction

    localparam logic [LANES-1:0] BOARD = mk_board();

    assert_idle_board_R2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (pat_o == BOARD));

    assert_word_held_two_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && run_en && !$stable(pat_o)) |=> $stable(pat_o));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (|($past(long_flag_o) & ~long_flag_o))) |-> $past(clr_cnt));

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clr_cnt)) |-> (long_flag_o == '0 && rd_data == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr_cnt) && rd_addr == $past(rd_addr))
            |-> (rd_data >= $past(rd_data)));

endmodule

bind lum_monitor lum_monitor_chk #(
    .LANES(LANES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst(rst), .run_en(run_en), .clr_cnt(clr_cnt),
    .rd_addr(rd_addr), .pat_o(pat_o), .rd_data(rd_data),
    .long_flag_o(long_flag_o)
);

// File: tb/lum_monitor_tb.sv
module lum_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [2:0] lat_sel = 3'd0;
    logic       clr_cnt = 1'b0;
    logic [3:0] ret_i;
    logic [4:0] rd_addr = 5'd0;
    logic [3:0] pat_o;
    logic [15:0] rd_data;
    logic [3:0] long_flag_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit scan_en = 1'b0;
    bit done = 1'b0;

    logic [3:0] inj = 4'd0;
    logic [3:0] dly_pat = 4'b0101;
    logic [3:0] hist [10];
    int ext_d = 0;

    // reference model state
    int m_cnt [4][8];
    bit m_flag [4];
    int m_len [4];
    bit m_dir [4];
    logic [3:0] m_p [10];
    logic [3:0] m_r [10];
    int m_streak = 0;
    int m_run = 0;
    logic [3:0] m_pat = 4'b0101;

    always #5 clk = ~clk;

    lum_monitor dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .lat_sel(lat_sel),
        .clr_cnt(clr_cnt), .ret_i(ret_i), .rd_addr(rd_addr),
        .pat_o(pat_o), .rd_data(rd_data), .long_flag_o(long_flag_o)
    );

    // external loop: delayed copy of the pattern with injected flips
    assign ret_i = dly_pat ^ inj;
    initial for (int i = 0; i < 10; i++) hist[i] = 4'b0101;
    always @(negedge clk) begin
        for (int i = 9; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = pat_o;
        dly_pat = hist[ext_d];
    end

    // behavioural model, evaluated on the same edges as the design
    always @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < 4; l++) begin
                for (int k = 0; k < 8; k++) m_cnt[l][k] = 0;
                m_flag[l] = 0; m_len[l] = 0; m_dir[l] = 0;
            end
            for (int i = 0; i < 10; i++) begin m_p[i] = 4'b0101; m_r[i] = 4'b0101; end
            m_streak = 0; m_run = 0; m_pat = 4'b0101;
        end else begin
            for (int i = 9; i > 0; i--) begin m_p[i] = m_p[i-1]; m_r[i] = m_r[i-1]; end
            m_p[0] = pat_o;
            m_r[0] = ret_i;
            m_streak = run_en ? ((m_streak < 100) ? m_streak + 1 : 100) : 0;
            for (int l = 0; l < 4; l++) begin
                bit e, g, ev;
                int b;
                e = m_p[2 + int'(lat_sel)][l];
                g = m_r[2][l];
                ev = 0; b = 0;
                if (m_streak >= 9 && e != g) begin
                    if (m_len[l] == 0) m_dir[l] = e;
                    m_len[l]++;
                    if (m_len[l] >= 4) m_flag[l] = 1;
                end else if (m_len[l] > 0) begin
                    ev = 1;
                    b = (m_len[l] > 3) ? 3 : m_len[l];
                    m_len[l] = 0;
                end
                if (ev) begin
                    if (m_cnt[l][0] < 65535) m_cnt[l][0]++;
                    if (m_cnt[l][b] < 65535) m_cnt[l][b]++;
                    if (m_dir[l]) begin
                        if (m_cnt[l][4] < 65535) m_cnt[l][4]++;
                    end else begin
                        if (m_cnt[l][5] < 65535) m_cnt[l][5]++;
                    end
                end
            end
            if (clr_cnt) begin
                for (int l = 0; l < 4; l++) begin
                    for (int k = 0; k < 8; k++) m_cnt[l][k] = 0;
                    m_flag[l] = 0;
                end
            end
            if (run_en) begin
                m_run++;
                m_pat = (((m_run / 2) % 2) == 1) ? 4'b1010 : 4'b0101;
            end else begin
                m_run = 0;
                m_pat = 4'b0101;
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [3:0] mf;
            int l, k;
            n_cmp++;
            if (pat_o !== m_pat) begin
                n_bad++;
                $display("FAIL R2 pattern: got %b expected %b", pat_o, m_pat);
            end
            for (int i = 0; i < 4; i++) mf[i] = m_flag[i];
            n_cmp++;
            if (long_flag_o !== mf) begin
                n_bad++;
                $display("FAIL R8 long flag: got %b expected %b", long_flag_o, mf);
            end
            l = int'(rd_addr[4:3]);
            k = int'(rd_addr[2:0]);
            n_cmp++;
            if (int'(rd_data) != m_cnt[l][k]) begin
                n_bad++;
                if (k == 0)
                    $display("FAIL R5 lane %0d total: got %0d expected %0d", l, rd_data, m_cnt[l][k]);
                else if (k <= 3)
                    $display("FAIL R6 lane %0d bin %0d: got %0d expected %0d", l, k, rd_data, m_cnt[l][k]);
                else if (k <= 5)
                    $display("FAIL R7 lane %0d dir %0d: got %0d expected %0d", l, k, rd_data, m_cnt[l][k]);
                else
                    $display("FAIL R11 addr %0d: got %0d expected %0d", rd_addr, rd_data, m_cnt[l][k]);
            end
            if (scan_en) rd_addr = rd_addr + 5'd1;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input int lane, input int kind, input int expv, input string tag);
        scan_en = 0;
        @(negedge clk);
        rd_addr = 5'(lane * 8 + kind);
        @(negedge clk);
        n_cmp++;
        if (int'(rd_data) != expv) begin
            n_bad++;
            $display("FAIL %s lane %0d kind %0d: got %0d expected %0d", tag, lane, kind, rd_data, expv);
        end
        scan_en = 1;
    endtask

    task automatic flag_chk(input logic [3:0] expv, input string tag);
        n_cmp++;
        if (long_flag_o !== expv) begin
            n_bad++;
            $display("FAIL %s flags: got %b expected %b", tag, long_flag_o, expv);
        end
    endtask

    task automatic burst(input int lane, input int len);
        @(negedge clk);
        inj[lane] = 1'b1;
        cyc(len);
        inj[lane] = 1'b0;
        cyc(6);
    endtask

    task automatic burst_phase(input int lane, input logic want);
        @(negedge clk);
        while (pat_o[lane] !== want) @(negedge clk);
        inj[lane] = 1'b1;
        @(negedge clk);
        inj[lane] = 1'b0;
        cyc(6);
    endtask

    task automatic clear();
        @(negedge clk); clr_cnt = 1'b1;
        @(negedge clk); clr_cnt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        n_cmp++;
        if (pat_o !== 4'b0101) begin
            n_bad++; $display("FAIL R1 pattern: got %b expected 0101", pat_o);
        end
        flag_chk(4'b0000, "R1");
        for (int l = 0; l < 4; l++)
            for (int k = 0; k < 6; k++) peek(l, k, 0, "R1");
        scan_en = 1;

        // R3 clean loop, zero latency
        run_en = 1'b1;
        cyc(100);
        for (int l = 0; l < 4; l++) peek(l, 0, 0, "R3");

        // R5 R6 single-edge bursts on lane 1
        burst(1, 1); burst(1, 1); burst(1, 1);
        peek(1, 0, 3, "R5");
        peek(1, 1, 3, "R6");

        // R7 known-direction bursts on lane 3
        burst_phase(3, 1'b1);
        burst_phase(3, 1'b0);
        peek(3, 4, 1, "R7");
        peek(3, 5, 1, "R7");

        // R6 R8 longer bursts on lane 2, R12 isolation
        burst(2, 2); burst(2, 3); burst(2, 5);
        peek(2, 2, 1, "R6");
        peek(2, 3, 2, "R6");
        flag_chk(4'b0100, "R8");
        peek(1, 0, 3, "R12");
        peek(0, 0, 0, "R12");
        peek(0, 6, 0, "R11");
        peek(2, 7, 0, "R11");

        // R10 clear
        clear();
        flag_chk(4'b0000, "R10");
        peek(1, 0, 0, "R10");
        peek(2, 3, 0, "R10");

        // R5 stop during an open event
        @(negedge clk);
        inj[1] = 1'b1;
        cyc(4);
        run_en = 1'b0;
        cyc(6);
        inj[1] = 1'b0;
        cyc(4);
        peek(1, 0, 1, "R5");
        peek(1, 2, 1, "R5");

        // R4 errors inside the start-up mask
        @(negedge clk);
        run_en = 1'b1;
        inj[3] = 1'b1;
        cyc(6);
        inj[3] = 1'b0;
        cyc(20);
        peek(3, 0, 0, "R4");

        // R3 latency 5 matched by a 5-cycle loop
        run_en = 1'b0;
        cyc(12);
        lat_sel = 3'd5;
        ext_d = 5;
        cyc(12);
        clear();
        run_en = 1'b1;
        cyc(80);
        for (int l = 0; l < 4; l++) peek(l, 0, 0, "R3");
        burst(0, 1);
        peek(0, 1, 1, "R3");

        // R9 saturation on lane 0
        clear();
        for (int i = 0; i < 132000; i++) begin
            @(negedge clk);
            inj[0] = i[0];
        end
        inj[0] = 1'b0;
        cyc(8);
        peek(0, 0, 65535, "R9");
        peek(0, 1, 65535, "R9");
        peek(0, 2, 0, "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule